// File: doc/BRIEF.md
# Constant Buffer Streaming Upload Unit

This unit holds the descriptor of the constant buffer that is being filled. The descriptor has a 64-bit base address, kept as separate upper and lower 32-bit words, a size in bytes and a write position in bytes. Configuration and data arrive as register writes on a valid/ready command stream. Each write carries a register index and a 32-bit word. A write to any of the data-port indices becomes a 32-bit memory write request at base plus position. After that write the position moves forward by four bytes, so a run of data writes fills the buffer one word after another.

Before it issues a request, the unit checks two things: the base address must be non-zero, and the word must fit inside the programmed size. A write that fails either check issues no request and leaves the position where it was. Each check has its own sticky fault flag, and only reset clears it. Requests go out on a valid/ready stream. A request stays on the pins, unchanged, until the memory side accepts it. The command stream is held off (`cfg_ready` low) for as long as a request is waiting.

Top module: `cbu_stream_upload`

## Requirements
- R1: After reset, `req_valid` is 0, `cfg_ready` is 1, both fault flags are 0, and the base, size and position all read as 0.
- R2: A command with index 16 through 31 is a data write. All sixteen of these indices behave the same way: when accepted and passing both checks, the data write produces one request with `req_addr` = base + position and `req_data` = the command word. `req_valid` rises on the clock edge that accepts the command.
- R3: Each data write that issues a request advances the position by 4 bytes.
- R4: A data write for which position + 4 is greater than size issues no request, leaves the position unchanged and sets `fault_bounds`. The sum is formed without wrap-around.
- R5: A data write while the 64-bit base is zero issues no request, leaves the position unchanged and sets `fault_null`. If both checks fail, both flags are set.
- R6: Index 0 writes the upper 32 bits of the base and index 1 writes the lower 32 bits. Each word can be written without touching the other.
- R7: Index 3 loads the position directly. The next data write uses the loaded value in place of the auto-incremented one. Index 2 loads the size.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_data` stay stable. While `req_valid` is high, `cfg_ready` is low, so no command of any kind is accepted until the request has been taken.
- R9: Once set, `fault_bounds` and `fault_null` stay set until reset, through later successful writes.
- R10: A command whose index is 4 through 15 or above 31 changes nothing and issues no request.
- R11: A data write with position + 4 exactly equal to size is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Command present |
| cfg_ready | output | 1 | Command accepted on this edge when high with cfg_valid |
| cfg_idx | input | 6 | Register index of the command |
| cfg_wdata | input | 32 | Command word |
| req_valid | output | 1 | Memory write request present |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | 64 | Byte address of the write |
| req_data | output | 32 | Word to write |
| fault_bounds | output | 1 | Sticky: a write past the buffer size was refused |
| fault_null | output | 1 | Sticky: a data write with a zero base was refused |

## Verification
The hardest case to reach from the ports is a refused write, because the proof that the position did not move only shows up later. The stimulus first fills the buffer exactly to its size, then sends one write too many. It then enlarges the size and writes again; the address of that write shows the position was left where it was. Back-pressure on the memory side is applied in a pseudo-random pattern while commands keep coming. This checks that a waiting request is held steady and that no command slips in behind it.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 2 * WORD_W;
  localparam int unsigned STEP     = 4;
  localparam int unsigned IDX_HI   = 0;
  localparam int unsigned IDX_LO   = 1;
  localparam int unsigned IDX_SIZE = 2;
  localparam int unsigned IDX_POS  = 3;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_HI   = 3'd1,
    K_LO   = 3'd2,
    K_SIZE = 3'd3,
    K_POS  = 3'd4,
    K_DATA = 3'd5
  } reg_kind_e;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
#(
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned DATA_BASE  = 16,
  parameter int unsigned DATA_PORTS = 16
) (
  input  logic [IDX_W-1:0] idx,
  output reg_kind_e        kind
);
  logic [DATA_PORTS-1:0] port_hit;

  for (genvar g = 0; g < DATA_PORTS; g++) begin : g_port
    assign port_hit[g] = (idx == IDX_W'(DATA_BASE + g));
  end

  always_comb begin
    kind = K_NONE;
    if (|port_hit)                     kind = K_DATA;
    else if (idx == IDX_W'(IDX_HI))    kind = K_HI;
    else if (idx == IDX_W'(IDX_LO))    kind = K_LO;
    else if (idx == IDX_W'(IDX_SIZE))  kind = K_SIZE;
    else if (idx == IDX_W'(IDX_POS))   kind = K_POS;
  end
endmodule

// File: rtl/cbu_desc.sv
module cbu_desc
  import cbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [WORD_W-1:0] wdata,
  input  logic              advance,
  output logic [ADDR_W-1:0] base,
  output logic [WORD_W-1:0] size,
  output logic [WORD_W-1:0] pos
);
  logic [WORD_W-1:0] base_hi, base_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      base_lo <= '0;
      size    <= '0;
      pos     <= '0;
    end else if (advance) begin
      pos <= pos + WORD_W'(STEP);
    end else if (wr_en) begin
      case (kind)
        K_HI:    base_hi <= wdata;
        K_LO:    base_lo <= wdata;
        K_SIZE:  size    <= wdata;
        K_POS:   pos     <= wdata;
        default: ;
      endcase
    end
  end

  assign base = {base_hi, base_lo};
endmodule

// File: rtl/cbu_check.sv
module cbu_check
  import cbu_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [WORD_W-1:0] size,
  input  logic [WORD_W-1:0] pos,
  output logic              null_err,
  output logic              bounds_err
);
  logic [WORD_W:0] end_pos;

  always_comb begin
    end_pos    = {1'b0, pos} + (WORD_W+1)'(STEP);
    bounds_err = end_pos > {1'b0, size};
    null_err   = (base == '0);
  end
endmodule

// File: rtl/cbu_req.sv
module cbu_req
  import cbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [WORD_W-1:0] data_in,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= addr_in;
      data  <= data_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cbu_stream_upload.sv
module cbu_stream_upload
  import cbu_pkg::*;
#(
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned DATA_BASE  = 16,
  parameter int unsigned DATA_PORTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [63:0]       req_addr,
  output logic [31:0]       req_data,
  output logic              fault_bounds,
  output logic              fault_null
);
  reg_kind_e         kind;
  logic              accept, data_hit, issue;
  logic              null_err, bounds_err;
  logic [ADDR_W-1:0] cur_base;
  logic [WORD_W-1:0] cur_size, cur_pos;

  cbu_decode #(
    .IDX_W(IDX_W), .DATA_BASE(DATA_BASE), .DATA_PORTS(DATA_PORTS)
  ) u_dec (
    .idx(cfg_idx), .kind(kind)
  );

  assign cfg_ready = ~req_valid;
  assign accept    = cfg_valid & cfg_ready;
  assign data_hit  = (kind == K_DATA);
  assign issue     = accept & data_hit & ~null_err & ~bounds_err;

  cbu_desc u_desc (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .kind(kind),
    .wdata(cfg_wdata), .advance(issue),
    .base(cur_base), .size(cur_size), .pos(cur_pos)
  );

  cbu_check u_chk (
    .base(cur_base), .size(cur_size), .pos(cur_pos),
    .null_err(null_err), .bounds_err(bounds_err)
  );

  cbu_req u_req (
    .clk(clk), .rst_n(rst_n), .load(issue),
    .addr_in(cur_base + ADDR_W'(cur_pos)), .data_in(cfg_wdata),
    .ready(req_ready), .valid(req_valid), .addr(req_addr), .data(req_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_bounds <= 1'b0;
      fault_null   <= 1'b0;
    end else if (accept && data_hit) begin
      if (bounds_err) fault_bounds <= 1'b1;
      if (null_err)   fault_null   <= 1'b1;
    end
  end
endmodule

// File: rtl/cbu_sva.sv
module cbu_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic        is_data,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic [31:0] req_data,
  input logic [63:0] base,
  input logic [31:0] size,
  input logic [31:0] pos,
  input logic        fault_bounds,
  input logic        fault_null
);
  logic acc_data, over;
  assign acc_data = cfg_valid && cfg_ready && is_data;
  assign over     = ({1'b0, pos} + 33'd4) > {1'b0, size};

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cfg_ready);

  assert_sticky_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_bounds |=> fault_bounds);

  assert_sticky_null_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_null |=> fault_null);

  assert_null_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data && base == 64'd0 |=> !req_valid && fault_null && $stable(pos));

  assert_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data && over |=> !req_valid && fault_bounds && $stable(pos));

  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data && base != 64'd0 && !over |=>
      req_valid && req_addr == $past(base) + {32'd0, $past(pos)});

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data && base != 64'd0 && !over |=> pos == $past(pos) + 32'd4);
endmodule

bind cbu_stream_upload cbu_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .is_data(data_hit), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_data(req_data), .base(cur_base),
  .size(cur_size), .pos(cur_pos), .fault_bounds(fault_bounds),
  .fault_null(fault_null)
);

// File: tb/sim_cbu_stream_upload.sv
`timescale 1ns/1ps
module sim_cbu_stream_upload;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [5:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [63:0] req_addr;
  logic [31:0] req_data;
  logic        fault_bounds, fault_null;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [95:0] expq[$];
  logic [31:0] m_hi, m_lo, m_size, m_pos;
  bit          m_fb, m_fn;
  bit          bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit          was_stall = 1'b0;
  logic [63:0] held_addr;
  logic [31:0] held_data;

  always #4 clk = ~clk;

  cbu_stream_upload u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
    .fault_bounds(fault_bounds), .fault_null(fault_null)
  );

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: drives ready at the falling edge, then scores the transfer
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_ready = bp_mode ? lfsr[0] : 1'b1;
      if (was_stall)
        check(req_valid && req_addr == held_addr && req_data == held_data,
              "R8 hold", {req_addr, req_data}, {held_addr, held_data});
      if (req_valid && cfg_ready) check(0, "R8 busy", 96'(cfg_ready), 96'd0);
      was_stall = req_valid && !req_ready;
      held_addr = req_addr;
      held_data = req_data;
      if (req_valid && req_ready) begin
        if (expq.size() == 0) check(0, "R2 unexpected request", {req_addr, req_data}, 96'd0);
        else begin
          logic [95:0] e;
          e = expq.pop_front();
          check({req_addr, req_data} == e, "R2/R3 request", {req_addr, req_data}, e);
        end
      end
    end else begin
      was_stall = 1'b0;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_hi = 0; m_lo = 0; m_size = 0; m_pos = 0; m_fb = 0; m_fn = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Driver: sends one command and updates the reference model
  task automatic put(input int idx, input logic [31:0] w);
    logic [32:0] endp;
    cfg_idx = 6'(idx); cfg_wdata = w; cfg_valid = 1'b1;
    while (!cfg_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    if (idx >= 16 && idx <= 31) begin
      endp = {1'b0, m_pos} + 33'd4;
      if ({m_hi, m_lo} == 64'd0) m_fn = 1;
      if (endp > {1'b0, m_size}) m_fb = 1;
      if ({m_hi, m_lo} != 64'd0 && endp <= {1'b0, m_size}) begin
        expq.push_back({{m_hi, m_lo} + {32'd0, m_pos}, w});
        m_pos = m_pos + 4;
      end
    end else if (idx == 0) m_hi = w;
    else if (idx == 1) m_lo = w;
    else if (idx == 2) m_size = w;
    else if (idx == 3) m_pos = w;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (expq.size() != 0 || req_valid); i++) @(negedge clk);
    check(expq.size() == 0 && !req_valid, "R2 all requests seen", 96'(expq.size()), 96'd0);
  endtask

  task automatic check_flags(input string req);
    check(fault_bounds == m_fb && fault_null == m_fn, req,
          96'({fault_bounds, fault_null}), 96'({m_fb, m_fn}));
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(!req_valid && cfg_ready && !fault_bounds && !fault_null, "R1 reset",
          96'({req_valid, cfg_ready, fault_bounds, fault_null}), 96'b0100);
    // R5 null base
    put(20, 32'hDEAD0001);
    repeat (3) @(negedge clk);
    check_flags("R5 null fault");
    check(!req_valid, "R5 no request", 96'(req_valid), 96'd0);
    // R6/R2/R3/R11 fill exactly
    put(0, 32'h1); put(1, 32'h1000); put(2, 32'h10);
    put(16, 32'hA0); put(31, 32'hA1); put(23, 32'hA2); put(19, 32'hA3);
    drain();
    // R4 one too many, R9 null still set
    put(17, 32'hBAD);
    drain();
    check_flags("R4 bounds fault / R9 sticky");
    // R7 position override
    put(3, 32'h4); put(24, 32'hC0);
    drain();
    check_flags("R9 sticky after success");

    // Second pass: R4 position unchanged, under back-pressure
    do_reset();
    check_flags("R1 flags cleared");
    bp_mode = 1'b1;
    put(0, 32'h0); put(1, 32'h8000); put(2, 32'h8); put(3, 32'h4);
    put(18, 32'h11); put(18, 32'h22);
    put(2, 32'h20); put(25, 32'h33);   // lands at +8: position was held
    drain();
    check_flags("R4 bounds after refused");
    // R10 unmapped indices, then R6 upper word only
    put(5, 32'hFFFF); put(15, 32'hFFFF); put(32, 32'hFFFF); put(63, 32'hFFFF);
    put(21, 32'h44);
    put(0, 32'h2); put(30, 32'h55); put(16, 32'h66); put(29, 32'h77);
    drain();
    check_flags("R10 flags unchanged");
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule